// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This unit sits beside an instruction fetch stage and runs counted loops without spending any instruction slots on loop bookkeeping. A loop-enter command gives the address of the loop-enter instruction, a 16-bit iteration count and an optional flag condition. The controller stores the address of the instruction that follows as the loop start. Each retiring instruction may carry an end-of-loop marker. On a marked instruction the controller lowers the count and, in the same cycle, either tells fetch to jump back to the loop start or lets it fall through.

Loops nest. Entering a loop while another one runs pushes the outer loop's context onto an internal stack, and leaving the inner loop pops it back. Leaving happens either when the loop is exhausted or when a branch unit requests an early exit. The stack has a parameterised depth. Pushing onto a full stack and asking for an exit with no loop running both raise one-cycle error pulses.

Top module: `hwloop_ctrl`

## Requirements
- R1: An accepted `enter_valid` records `enter_pc + STEP` as the loop start, together with `enter_count`, `enter_cond_en` and `enter_cond_sel`. `loop_busy` is 1 from the next cycle on.
- R2: An `eol_valid` in an active loop lowers the stored count by one, saturating at 0. While the lowered count is non-zero the loop repeats, and a count of N (N ≥ 1) gives N passes through the body.
- R3: A loaded count of 0 or 1 with no condition gives exactly one pass: the first end-of-loop marker does not redirect.
- R4: With `enter_cond_en`=1, the loop also repeats while the flag at bit index `enter_cond_sel` of `flags` reads 0 at the end-of-loop marker. This holds even once the count has reached 0.
- R5: With `enter_cond_en`=0, `flags` has no effect, and only the count decides between repeat and exit.
- R6: `redirect_valid` and `redirect_addr` are combinational in the cycle of the end-of-loop marker, so a taken loop-back costs no extra cycle.
- R7: Entering a loop while one is active saves the outer loop. When the inner loop exits, the outer loop resumes with its start address and its remaining count unchanged.
- R8: `brk_exit` leaves the current loop at once and restores the enclosing loop if there is one. It also takes precedence over an end-of-loop marker in the same cycle, which then produces no redirect.
- R9: An enter while a loop is active and DEPTH contexts are already saved pulses `err_overflow` in the next cycle. The new loop is not entered and the running loop is unchanged.
- R10: A `brk_exit` with no loop active pulses `err_underflow` in the next cycle and has no other effect.
- R11: An `eol_valid` with no loop active produces no redirect and has no effect.
- R12: During and after reset `loop_busy`, `redirect_valid`, `err_overflow` and `err_underflow` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enter_valid | input | 1 | Loop-enter command |
| enter_pc | input | ADDR_W | Address of the loop-enter instruction |
| enter_count | input | CNT_W | Iteration count |
| enter_cond_en | input | 1 | Selects the flag condition |
| enter_cond_sel | input | SEL_W | Index of the flag that gates the loop |
| eol_valid | input | 1 | A retiring instruction carries the end-of-loop marker |
| brk_exit | input | 1 | Early-exit request from the branch unit |
| flags | input | NFLAG | Current condition flags |
| redirect_valid | output | 1 | Fetch must jump to `redirect_addr` |
| redirect_addr | output | ADDR_W | Loop start of the active loop |
| loop_busy | output | 1 | A loop is active |
| err_overflow | output | 1 | One-cycle pulse: enter refused, stack full |
| err_underflow | output | 1 | One-cycle pulse: exit requested with no loop active |

## Verification
The assertions assume that a loop-enter never arrives in the same cycle as an end-of-loop marker or an early exit, because a decoder issues one of these per instruction. They also assume that stack push and pop never coincide, which follows from the first assumption. The stimulus respects this rule: the directed tasks issue one command per cycle, and the random phase draws exactly one command kind per cycle. Flags are mostly held at 1 during random runs, so that conditional loops end in reasonable time.

// File: rtl/hwloop_pkg.sv
`timescale 1ns/1ps
package hwloop_pkg;
  // Decoded per-cycle command; enter outranks break, break outranks end-of-loop.
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_ENTER = 2'd1,
    ACT_BREAK = 2'd2,
    ACT_EOL   = 2'd3
  } loop_act_e;
endpackage

// File: rtl/hwloop_stack.sv
`timescale 1ns/1ps
module hwloop_stack #(
  parameter int W     = 35,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] sp;
  logic [PTR_W-1:0] sp_m1;

  assign sp_m1 = sp - PTR_W'(1);
  assign empty = (sp == '0);
  assign full  = (sp == PTR_W'(DEPTH));
  assign rdata = mem[sp_m1[IDX_W-1:0]];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[sp[IDX_W-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) sp <= '0;
    else if (push && !pop) sp <= sp + PTR_W'(1);
    else if (pop && !push) sp <= sp_m1;
  end

  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst) push |-> !full); // R9
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst) pop |-> !empty); // R7
  AST_NO_PUSH_POP:  assert property (@(posedge clk) disable iff (rst) !(push && pop)); // R7
endmodule

// File: rtl/hwloop_eval.sv
`timescale 1ns/1ps
module hwloop_eval #(
  parameter int CNT_W = 16,
  parameter int NFLAG = 4,
  parameter int SEL_W = 2
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             cond_en,
  input  logic [SEL_W-1:0] cond_sel,
  input  logic [NFLAG-1:0] flags,
  output logic [CNT_W-1:0] cnt_next,
  output logic             again
);
  logic flag_bit;

  // saturating decrement: a count of zero behaves as a single pass
  assign cnt_next = (cnt == '0) ? '0 : cnt - CNT_W'(1);
  assign flag_bit = flags[cond_sel];
  assign again    = (cnt_next != '0) || (cond_en && !flag_bit);
endmodule

// File: rtl/hwloop_ctrl.sv
`timescale 1ns/1ps
module hwloop_ctrl
  import hwloop_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DEPTH  = 4,
  parameter int NFLAG  = 4,
  parameter int STEP   = 1,
  parameter int SEL_W  = (NFLAG > 1) ? $clog2(NFLAG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enter_valid,
  input  logic [ADDR_W-1:0] enter_pc,
  input  logic [CNT_W-1:0]  enter_count,
  input  logic              enter_cond_en,
  input  logic [SEL_W-1:0]  enter_cond_sel,
  input  logic              eol_valid,
  input  logic              brk_exit,
  input  logic [NFLAG-1:0]  flags,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_addr,
  output logic              loop_busy,
  output logic              err_overflow,
  output logic              err_underflow
);
  localparam int CTX_W = ADDR_W + CNT_W + 1 + SEL_W;

  logic              cur_act;
  logic [ADDR_W-1:0] cur_start;
  logic [CNT_W-1:0]  cur_cnt;
  logic              cur_cen;
  logic [SEL_W-1:0]  cur_sel;

  loop_act_e  act;
  logic       ovf_hit, unf_hit, take_enter, eol_live, leave;
  logic       st_push, st_pop, st_empty, st_full;
  logic [CTX_W-1:0] st_wdata, st_rdata;
  logic [CNT_W-1:0] cnt_next;
  logic             again;

  always_comb begin
    act = ACT_IDLE;
    if (enter_valid)   act = ACT_ENTER;
    else if (brk_exit) act = ACT_BREAK;
    else if (eol_valid) act = ACT_EOL;
  end

  hwloop_eval #(.CNT_W(CNT_W), .NFLAG(NFLAG), .SEL_W(SEL_W)) u_eval (
    .cnt      (cur_cnt),
    .cond_en  (cur_cen),
    .cond_sel (cur_sel),
    .flags    (flags),
    .cnt_next (cnt_next),
    .again    (again)
  );

  assign ovf_hit    = (act == ACT_ENTER) && cur_act && st_full;
  assign unf_hit    = (act == ACT_BREAK) && !cur_act;
  assign take_enter = (act == ACT_ENTER) && !ovf_hit;
  assign eol_live   = (act == ACT_EOL) && cur_act;
  assign leave      = ((act == ACT_BREAK) && cur_act) || (eol_live && !again);
  assign st_push    = take_enter && cur_act;
  assign st_pop     = leave && !st_empty;
  assign st_wdata   = {cur_start, cur_cnt, cur_cen, cur_sel};

  hwloop_stack #(.W(CTX_W), .DEPTH(DEPTH)) u_stack (
    .clk   (clk),
    .rst   (rst),
    .push  (st_push),
    .pop   (st_pop),
    .wdata (st_wdata),
    .rdata (st_rdata),
    .empty (st_empty),
    .full  (st_full)
  );

  // fetch sees the loop-back in the same cycle as the marker
  assign redirect_valid = eol_live && again;
  assign redirect_addr  = cur_start;
  assign loop_busy      = cur_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_act   <= 1'b0;
      cur_start <= '0;
      cur_cnt   <= '0;
      cur_cen   <= 1'b0;
      cur_sel   <= '0;
    end else if (take_enter) begin
      cur_act   <= 1'b1;
      cur_start <= enter_pc + ADDR_W'(STEP);
      cur_cnt   <= enter_count;
      cur_cen   <= enter_cond_en;
      cur_sel   <= enter_cond_sel;
    end else if (leave) begin
      if (!st_empty) begin
        {cur_start, cur_cnt, cur_cen, cur_sel} <= st_rdata;
      end else begin
        cur_act <= 1'b0;
      end
    end else if (eol_live) begin
      cur_cnt <= cnt_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_overflow  <= 1'b0;
      err_underflow <= 1'b0;
    end else begin
      err_overflow  <= ovf_hit;
      err_underflow <= unf_hit;
    end
  end

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (rst)
    enter_valid |-> !(eol_valid || brk_exit)); // R1
  AST_ENTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    take_enter |=> loop_busy); // R1
  AST_REPEAT_STAYS: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |=> loop_busy); // R2
  AST_SINGLE_PASS: assert property (@(posedge clk) disable iff (rst)
    (eol_live && (cur_cnt <= CNT_W'(1)) && !cur_cen) |-> !redirect_valid); // R3
  AST_RESTORE_OUTER: assert property (@(posedge clk) disable iff (rst)
    (leave && !st_empty) |=> loop_busy); // R7
  AST_BREAK_NO_REDIR: assert property (@(posedge clk) disable iff (rst)
    brk_exit |-> !redirect_valid); // R8
  AST_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (rst)
    (enter_valid && loop_busy && st_full) |=> (err_overflow && loop_busy)); // R9
  AST_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (rst)
    (brk_exit && !enter_valid && !loop_busy) |=> (err_underflow && !loop_busy)); // R10
  AST_IDLE_EOL: assert property (@(posedge clk) disable iff (rst)
    !loop_busy |-> !redirect_valid); // R11
endmodule

// File: tb/sim_hwloop_ctrl.sv
`timescale 1ns/1ps
module sim_hwloop_ctrl;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        enter_valid, enter_cond_en, eol_valid, brk_exit;
  logic [15:0] enter_pc, enter_count;
  logic [1:0]  enter_cond_sel;
  logic [3:0]  flags;
  logic        redirect_valid, loop_busy, err_overflow, err_underflow;
  logic [15:0] redirect_addr;

  always #5 clk = ~clk;

  hwloop_ctrl #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst),
    .enter_valid(enter_valid), .enter_pc(enter_pc), .enter_count(enter_count),
    .enter_cond_en(enter_cond_en), .enter_cond_sel(enter_cond_sel),
    .eol_valid(eol_valid), .brk_exit(brk_exit), .flags(flags),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
    .loop_busy(loop_busy), .err_overflow(err_overflow), .err_underflow(err_underflow)
  );

  typedef struct { int start; int cnt; bit cen; int sel; } ctx_t;
  ctx_t saved[$];
  ctx_t m_cur;
  bit   m_act;

  int nchk = 0, nfail = 0;
  int red_n = 0, last_ra = -1;
  bit done = 0;

  task automatic chk(input int act, input int exp, input string tag);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic leave_model();
    if (saved.size() > 0) m_cur = saved.pop_back();
    else m_act = 0;
  endtask

  // one clock: drive at the falling edge, check outputs, update the model
  task automatic cyc(input bit en, input int pc, input int cnt, input bit cen,
                     input int csel, input bit eol, input bit brk, input logic [3:0] flg);
    bit exp_rv, e_ovf, e_unf;
    enter_valid = en; enter_pc = 16'(pc); enter_count = 16'(cnt);
    enter_cond_en = cen; enter_cond_sel = 2'(csel);
    eol_valid = eol; brk_exit = brk; flags = flg;
    #1;
    exp_rv = eol && !brk && !en && m_act &&
             ((m_cur.cnt > 1) || (m_cur.cen && !flg[m_cur.sel]));
    chk(int'(redirect_valid), int'(exp_rv), "R6 same-cycle redirect");
    if (exp_rv) chk(int'(redirect_addr), m_cur.start, "R2 redirect target");
    if (redirect_valid) begin red_n++; last_ra = int'(redirect_addr); end
    @(posedge clk);
    e_ovf = 0; e_unf = 0;
    if (en) begin
      if (m_act && saved.size() == DEPTH) e_ovf = 1;
      else begin
        if (m_act) saved.push_back(m_cur);
        m_cur = '{(pc + 1) & 16'hffff, cnt, cen, csel};
        m_act = 1;
      end
    end else if (brk) begin
      if (!m_act) e_unf = 1; else leave_model();
    end else if (eol && m_act) begin
      if (exp_rv) m_cur.cnt = (m_cur.cnt > 0) ? m_cur.cnt - 1 : 0;
      else leave_model();
    end
    @(negedge clk);
    chk(int'(loop_busy), int'(m_act), "R7 loop_busy");
    chk(int'(err_overflow), int'(e_ovf), "R9 overflow pulse");
    chk(int'(err_underflow), int'(e_unf), "R10 underflow pulse");
  endtask

  task automatic enter(input int pc, input int cnt, input bit cen, input int sel);
    cyc(1, pc, cnt, cen, sel, 0, 0, 4'hF);
  endtask
  task automatic eol(input logic [3:0] flg);
    cyc(0, 0, 0, 0, 0, 1, 0, flg);
  endtask
  task automatic brk();
    cyc(0, 0, 0, 0, 0, 0, 1, 4'hF);
  endtask

  task automatic do_reset();
    rst = 1; enter_valid = 0; eol_valid = 0; brk_exit = 0; enter_pc = 0;
    enter_count = 0; enter_cond_en = 0; enter_cond_sel = 0; flags = 4'hF;
    @(posedge clk); @(posedge clk); #1;
    chk(int'(loop_busy), 0, "R12 busy in reset");
    chk(int'(redirect_valid), 0, "R12 redirect in reset");
    chk(int'(err_overflow | err_underflow), 0, "R12 errors in reset");
    @(negedge clk); rst = 0;
    saved.delete(); m_act = 0; m_cur = '{0, 0, 0, 0};
  endtask

  initial begin
    do_reset();

    // R1 R2 R5: count 3, no condition, flags toggling must not matter
    red_n = 0;
    enter(100, 3, 0, 0);
    chk(int'(loop_busy), 1, "R1 busy after enter");
    eol(4'h0); eol(4'h0); eol(4'h0);
    chk(red_n, 2, "R2 three passes give two loop-backs");
    chk(last_ra, 101, "R1 start is next address");
    chk(int'(loop_busy), 0, "R5 exit by count only");

    // R3: counts of zero and one give one pass
    red_n = 0;
    enter(50, 0, 0, 0); eol(4'hF);
    enter(60, 1, 0, 0); eol(4'hF);
    chk(red_n, 0, "R3 single pass");

    // R4: condition on flag 2 keeps looping while it reads 0
    red_n = 0;
    enter(70, 1, 1, 2);
    eol(4'b1011); eol(4'b1011); eol(4'b0100);
    chk(red_n, 2, "R4 flag-held repeats");
    chk(int'(loop_busy), 0, "R4 exit once flag set");

    // R7: nesting restores the outer loop
    red_n = 0;
    enter(200, 2, 0, 0); enter(210, 2, 0, 0);
    eol(4'hF); chk(last_ra, 211, "R7 inner target");
    eol(4'hF);
    chk(int'(loop_busy), 1, "R7 outer restored");
    eol(4'hF); chk(last_ra, 201, "R7 outer target");
    eol(4'hF);
    chk(red_n, 2, "R7 nested loop-back count");
    chk(int'(loop_busy), 0, "R7 all loops done");

    // R8: early exit and its precedence
    red_n = 0;
    enter(300, 5, 0, 0); enter(400, 5, 0, 0);
    brk();
    chk(int'(loop_busy), 1, "R8 outer restored after break");
    eol(4'hF); chk(last_ra, 301, "R8 outer resumes");
    cyc(0, 0, 0, 0, 0, 1, 1, 4'hF);
    chk(red_n, 1, "R8 break beats end-of-loop");
    chk(int'(loop_busy), 0, "R8 break left last loop");

    // R10 R11: idle break and idle end-of-loop
    red_n = 0;
    brk();
    eol(4'h0);
    chk(red_n, 0, "R11 idle end-of-loop ignored");

    // R9: overflow leaves the running loop untouched
    do_reset();
    for (int i = 1; i <= 5; i++) enter(10 * i, 3, 0, 0);
    enter(60, 3, 0, 0);
    eol(4'hF);
    chk(last_ra, 51, "R9 running loop unchanged");

    // mixed traffic compared against the model each clock
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      int k;
      logic [3:0] f;
      k = $urandom % 8;
      f = (($urandom % 4) == 0) ? 4'($urandom) : 4'hF;
      case (k)
        0: enter($urandom % 65536, $urandom % 4, 1'($urandom), $urandom % 4);
        1: brk();
        2, 3, 4, 5: eol(f);
        default: cyc(0, 0, 0, 0, 0, 0, 0, f);
      endcase
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      nfail++;
      $display("FAIL R6 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule